// File: doc/BRIEF.md
# Load-Store Disambiguation Predictor

This block decides, at the moment a load is dispatched, whether that load may run ahead of older stores whose addresses are not yet known. The decision comes from a table of small saturating counters. The table is indexed by a fold of the load's instruction pointer. The table is read at dispatch. It is written only when the load retires: a clean bypass makes the counter grow, and any collision with a late-resolving older store clears it.

Up to eight loads are tracked while they are in flight. Each dispatched store address is compared against the tracked loads that the caller marks as younger than that store. A match marks that load as collided. When a load retires having bypassed and also been marked as collided, the block raises a restart request for that load. The flush itself happens outside the block. A watchdog counts restarts over a window of retirements. When the count goes above a programmable limit, it forces every prediction to "no go" for a fixed number of cycles.

Top module: `ldDisambigPredictor`

## Requirements
- R1: The table index is an XOR fold of the instruction pointer: bit b of the pointer is XORed into index bit (b mod 6). Two loads with the same index share one counter and see the same prediction.
- R2: After reset every counter is zero. The lookup output lkGo is 1 only when the counter at the looked-up index equals 3 and the watchdog is not active.
- R3: When a tracked load retires with its update bit set and its reset bit clear, its counter increments and saturates at 3. The update bit is set when lkUnknown was 1 at dispatch.
- R4: When a tracked load retires with its reset bit set, its counter is cleared to zero. This holds whether or not the load bypassed.
- R5: When a tracked load retires with neither its update bit nor its reset bit set, its counter is left unchanged.
- R6: A store sets the reset bit of tracker slot i only when bit i of stYoungMask is 1, the slot holds a load, and stAddr equals that load's address. No other store changes that bit.
- R7: rtRestart is 1 in the retire cycle exactly when the retiring slot has both its done bit and its reset bit set. The done bit is set when lkUnknown and lkGo were both 1 at dispatch.
- R8: When a lookup and a retirement update hit the same counter in one cycle, lkGo in that cycle reflects the value held before the update.
- R9: Restarts are counted within a window of 256 retirements, and the count is cleared at the end of each window. When a restart brings the count above wdLimit, wdOff rises and stays high for exactly 1024 cycles.
- R10: While wdOff is high, lkGo is 0 for every pointer, and retirements still update the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Load dispatch: allocate tracker slot |
| lkIp | input | 32 | Instruction pointer of the looked-up load |
| lkAddr | input | 16 | Memory address of the dispatched load |
| lkSlot | input | 3 | Tracker slot given to the load |
| lkUnknown | input | 1 | An older store address is still unknown |
| lkGo | output | 1 | 1 = load may bypass unknown stores |
| stValid | input | 1 | A store address has been dispatched |
| stAddr | input | 16 | Store address |
| stYoungMask | input | 8 | Slots holding loads younger than this store |
| rtValid | input | 1 | Load retirement |
| rtSlot | input | 3 | Tracker slot of the retiring load |
| rtRestart | output | 1 | Restart request for the retiring load |
| wdLimit | input | 8 | Restart count that may be reached without disabling |
| wdOff | output | 1 | Watchdog has disabled disambiguation |

## Verification
On every cycle the assertions check four things: a restart is only raised during a retirement, no "go" is given while the watchdog is active, the watchdog only trips on a restart, and once tripped it stays active past the next edge. Other behaviour is visible only in the bench's scenarios. This covers the counting, saturation and clearing of the counters and the aliasing between pointers that fold to one index. It also covers store filtering by age mask and address, and the old-value rule for a same-cycle lookup and update. Finally, it covers the window clearing and the exact length of the disable period.

// File: rtl/ldPredPkg.sv
package ldPredPkg;
  // Facts about the retiring load, datapath to control
  typedef struct packed {
    logic hit;
    logic upd;
    logic rst;
    logic done;
  } retInfo_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic incr;
    logic clear;
    logic restart;
  } ctlStrobe_t;
endpackage

// File: rtl/ldPredDatapath.sv
module ldPredDatapath
  import ldPredPkg::*;
#(
  parameter int IP_W   = 32,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 2,
  parameter int SLOTS  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     lkValid,
  input  logic [IP_W-1:0]          lkIp,
  input  logic [ADDR_W-1:0]        lkAddr,
  input  logic [$clog2(SLOTS)-1:0] lkSlot,
  input  logic                     lkUnknown,
  input  logic                     goAllow,
  output logic                     lkGo,
  input  logic                     stValid,
  input  logic [ADDR_W-1:0]        stAddr,
  input  logic [SLOTS-1:0]         stYoungMask,
  input  logic                     rtValid,
  input  logic [$clog2(SLOTS)-1:0] rtSlot,
  input  ctlStrobe_t               strobe,
  output retInfo_t                 retInfo
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [IDX_W-1:0] foldIp(input logic [IP_W-1:0] ip);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int b = 0; b < IP_W; b++) h[b % IDX_W] ^= ip[b];
    return h;
  endfunction

  logic [CNT_W-1:0]  cntTab [ENTRIES];
  logic [SLOTS-1:0]  trkValid, trkUpd, trkDone, trkRst;
  logic [IDX_W-1:0]  trkIdx  [SLOTS];
  logic [ADDR_W-1:0] trkAddr [SLOTS];
  logic [IDX_W-1:0]  lkIdx, rtIdx;

  assign lkIdx = foldIp(lkIp);
  assign rtIdx = trkIdx[rtSlot];
  assign lkGo  = goAllow && (cntTab[lkIdx] == CNT_MAX);

  assign retInfo.hit  = rtValid && trkValid[rtSlot];
  assign retInfo.upd  = trkUpd[rtSlot];
  assign retInfo.rst  = trkRst[rtSlot];
  assign retInfo.done = trkDone[rtSlot];

  // Counter table: written only at retirement
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < ENTRIES; e++) cntTab[e] <= '0;
    end else if (strobe.clear) begin
      cntTab[rtIdx] <= '0;
    end else if (strobe.incr && cntTab[rtIdx] != CNT_MAX) begin
      cntTab[rtIdx] <= cntTab[rtIdx] + 1'b1;
    end
  end

  // In-flight load tracker
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trkValid <= '0;
      trkUpd   <= '0;
      trkDone  <= '0;
      trkRst   <= '0;
      for (int s = 0; s < SLOTS; s++) begin
        trkIdx[s]  <= '0;
        trkAddr[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SLOTS; s++) begin
        if (lkValid && lkSlot == s) begin
          trkValid[s] <= 1'b1;
          trkIdx[s]   <= lkIdx;
          trkAddr[s]  <= lkAddr;
          trkUpd[s]   <= lkUnknown;
          trkDone[s]  <= lkUnknown && lkGo;
          trkRst[s]   <= 1'b0;
        end else begin
          if (rtValid && rtSlot == s) trkValid[s] <= 1'b0;
          if (stValid && trkValid[s] && stYoungMask[s] && trkAddr[s] == stAddr)
            trkRst[s] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ldPredControl.sv
module ldPredControl
  import ldPredPkg::*;
#(
  parameter int WINDOW = 256,
  parameter int HOLD   = 1024
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  retInfo_t                  retInfo,
  input  logic [$clog2(WINDOW)-1:0] wdLimit,
  output ctlStrobe_t                strobe,
  output logic                      wdOff
);
  localparam int WIN_W  = $clog2(WINDOW);
  localparam int RC_W   = WIN_W + 1;
  localparam int HOLD_W = $clog2(HOLD);

  logic [WIN_W-1:0]  loadCnt;
  logic [RC_W-1:0]   restartCnt, restartNext;
  logic [HOLD_W-1:0] holdTimer;

  assign strobe.incr    = retInfo.hit && retInfo.upd && !retInfo.rst;
  assign strobe.clear   = retInfo.hit && retInfo.rst;
  assign strobe.restart = retInfo.hit && retInfo.rst && retInfo.done;

  always_comb restartNext = restartCnt + RC_W'(strobe.restart);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdOff      <= 1'b0;
      holdTimer  <= '0;
      loadCnt    <= '0;
      restartCnt <= '0;
    end else if (wdOff) begin
      loadCnt    <= '0;
      restartCnt <= '0;
      if (holdTimer == '0) wdOff <= 1'b0;
      else holdTimer <= holdTimer - 1'b1;
    end else if (restartNext > {1'b0, wdLimit}) begin
      wdOff      <= 1'b1;
      holdTimer  <= HOLD_W'(HOLD - 1);
      loadCnt    <= '0;
      restartCnt <= '0;
    end else if (retInfo.hit) begin
      if (loadCnt == WIN_W'(WINDOW - 1)) begin
        loadCnt    <= '0;
        restartCnt <= '0;
      end else begin
        loadCnt    <= loadCnt + 1'b1;
        restartCnt <= restartNext;
      end
    end
  end
endmodule

// File: rtl/ldDisambigPredictor.sv
module ldDisambigPredictor
  import ldPredPkg::*;
#(
  parameter int IP_W   = 32,
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 2,
  parameter int SLOTS  = 8,
  parameter int WINDOW = 256,
  parameter int HOLD   = 1024,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int WIN_W  = $clog2(WINDOW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [IP_W-1:0]   lkIp,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic [SLOT_W-1:0] lkSlot,
  input  logic              lkUnknown,
  output logic              lkGo,
  input  logic              stValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [SLOTS-1:0]  stYoungMask,
  input  logic              rtValid,
  input  logic [SLOT_W-1:0] rtSlot,
  output logic              rtRestart,
  input  logic [WIN_W-1:0]  wdLimit,
  output logic              wdOff
);
  retInfo_t   retInfo;
  ctlStrobe_t strobe;

  ldPredDatapath #(
    .IP_W(IP_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W), .SLOTS(SLOTS)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .lkValid(lkValid), .lkIp(lkIp), .lkAddr(lkAddr), .lkSlot(lkSlot),
    .lkUnknown(lkUnknown), .goAllow(!wdOff), .lkGo(lkGo),
    .stValid(stValid), .stAddr(stAddr), .stYoungMask(stYoungMask),
    .rtValid(rtValid), .rtSlot(rtSlot), .strobe(strobe), .retInfo(retInfo)
  );

  ldPredControl #(.WINDOW(WINDOW), .HOLD(HOLD)) u_ctl (
    .clk(clk), .rstN(rstN), .retInfo(retInfo), .wdLimit(wdLimit),
    .strobe(strobe), .wdOff(wdOff)
  );

  assign rtRestart = strobe.restart;
endmodule

// File: rtl/ldDisambigPredictor_chk.sv
module ldDisambigPredictor_chk (
  input logic clk,
  input logic rstN,
  input logic rtValid,
  input logic rtRestart,
  input logic lkGo,
  input logic wdOff
);
  // R7: a restart request only accompanies a retirement
  p_restart_on_retire_r7: assert property (@(posedge clk) disable iff (!rstN)
    rtRestart |-> rtValid);

  // R10: no go while the watchdog holds disambiguation off
  p_no_go_when_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    wdOff |-> !lkGo);

  // R9: the watchdog trips only on the cycle after a restart
  p_trip_after_restart_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdOff) |-> $past(rtRestart));

  // R9: a trip is held beyond the next edge
  p_trip_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdOff) |=> wdOff);
endmodule

bind ldDisambigPredictor ldDisambigPredictor_chk u_chk (
  .clk(clk), .rstN(rstN), .rtValid(rtValid), .rtRestart(rtRestart),
  .lkGo(lkGo), .wdOff(wdOff)
);

// File: tb/ldDisambigPredictor_bench.sv
module ldDisambigPredictor_bench;
  localparam int HOLD = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0, lkUnknown = 1'b0, stValid = 1'b0, rtValid = 1'b0;
  logic [31:0] lkIp = '0;
  logic [15:0] lkAddr = '0, stAddr = '0;
  logic [2:0]  lkSlot = '0, rtSlot = '0;
  logic [7:0]  stYoungMask = '0, wdLimit = 8'd200;
  logic        lkGo, rtRestart, wdOff;

  int errors = 0, checks = 0, cyc = 0;

  ldDisambigPredictor u_ldDisambigPredictor (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkIp(lkIp), .lkAddr(lkAddr),
    .lkSlot(lkSlot), .lkUnknown(lkUnknown), .lkGo(lkGo), .stValid(stValid),
    .stAddr(stAddr), .stYoungMask(stYoungMask), .rtValid(rtValid),
    .rtSlot(rtSlot), .rtRestart(rtRestart), .wdLimit(wdLimit), .wdOff(wdOff)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [5:0] foldB(input logic [31:0] ip);
    logic [5:0] h = '0;
    for (int b = 0; b < 32; b++) h[b % 6] ^= ip[b];
    return h;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [7:0] lim);
    @(negedge clk);
    rstN = 1'b0; wdLimit = lim;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;
  endtask

  task automatic peek(input logic [31:0] ip, output logic g);
    lkIp = ip;
    #1 g = lkGo;
  endtask

  task automatic dispatch(input logic [31:0] ip, input logic [2:0] slot,
                          input logic [15:0] addr, input logic unk, output logic g);
    @(negedge clk);
    lkValid = 1'b1; lkIp = ip; lkSlot = slot; lkAddr = addr; lkUnknown = unk;
    #1 g = lkGo;
    @(posedge clk);
    #1 lkValid = 1'b0;
  endtask

  task automatic store(input logic [15:0] addr, input logic [7:0] mask);
    @(negedge clk);
    stValid = 1'b1; stAddr = addr; stYoungMask = mask;
    @(posedge clk);
    #1 stValid = 1'b0;
  endtask

  task automatic retire(input logic [2:0] slot, output logic rs);
    @(negedge clk);
    rtValid = 1'b1; rtSlot = slot;
    #1 rs = rtRestart;
    @(posedge clk);
    #1 rtValid = 1'b0;
  endtask

  task automatic train(input logic [31:0] ip, input logic unk);
    logic g, rs;
    dispatch(ip, 3'd0, 16'h0010, unk, g);
    retire(3'd0, rs);
  endtask

  // Bring the counter of ip to 3, bypass, collide, retire; returns restart
  task automatic restartSeq(input logic [31:0] ip, output logic rs);
    logic g;
    repeat (3) train(ip, 1'b1);
    dispatch(ip, 3'd1, 16'h0300, 1'b1, g);
    store(16'h0300, 8'b0000_0010);
    retire(3'd1, rs);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic g, rs;
    logic [31:0] ipA, ipAl, ipB;
    int rise;
    ipA  = 32'h0000_0040;  // folds to index 1 (bit 6 -> index bit 0)
    ipAl = 32'h0000_0001;  // same index as ipA
    ipB  = 32'h0000_0002;  // index 2

    doReset(8'd200);
    // R2: reset state
    for (int k = 0; k < 64; k++) begin
      peek(32'(k), g);
      check("R2 reset go", int'(g), 0);
    end
    check("R7 reset restart", int'(rtRestart), 0);
    check("R9 reset wdOff", int'(wdOff), 0);

    // R3: three clean bypass retirements saturate
    for (int n = 1; n <= 4; n++) begin
      train(ipA, 1'b1);
      peek(ipA, g);
      check("R3 count to saturation", int'(g), int'(n >= 3));
    end

    // R1: sweep pointers, go only where the fold matches ipA
    for (int k = 0; k < 300; k++) begin
      logic [31:0] ip = 32'(k * 40503 + 7);
      peek(ip, g);
      check("R1 fold sharing", int'(g), int'(foldB(ip) == foldB(ipA)));
    end

    // R5: retire without update bit leaves counter unchanged
    train(ipB, 1'b1); train(ipB, 1'b1);
    train(ipB, 1'b0); train(ipB, 1'b0);
    peek(ipB, g);
    check("R5 no change (no incr)", int'(g), 0);
    train(ipB, 1'b1);
    peek(ipB, g);
    check("R5 no change (kept 2)", int'(g), 1);

    // R6: store filtered by mask and address
    dispatch(ipA, 3'd2, 16'h0100, 1'b1, g);
    check("R7 go at dispatch", int'(g), 1);
    store(16'h0100, 8'b1111_1011);
    retire(3'd2, rs);
    check("R6 mask bit clear ignored", int'(rs), 0);
    peek(ipA, g);
    check("R6 counter kept after masked store", int'(g), 1);
    dispatch(ipA, 3'd2, 16'h0100, 1'b1, g);
    store(16'h0104, 8'b0000_0100);
    retire(3'd2, rs);
    check("R6 address mismatch ignored", int'(rs), 0);
    peek(ipA, g);
    check("R6 counter kept after mismatch", int'(g), 1);

    // R7 and R4: collision after bypass
    dispatch(ipA, 3'd3, 16'h0200, 1'b1, g);
    store(16'h0200, 8'b0000_1000);
    retire(3'd3, rs);
    check("R7 restart on collided bypass", int'(rs), 1);
    peek(ipA, g);
    check("R4 cleared after collision", int'(g), 0);
    peek(ipAl, g);
    check("R1 alias also cleared", int'(g), 0);

    // R4/R7: collision without bypass still clears, no restart
    train(ipA, 1'b1); train(ipA, 1'b1);
    dispatch(ipA, 3'd4, 16'h0220, 1'b1, g);
    check("R2 no go at count 2", int'(g), 0);
    store(16'h0220, 8'b0001_0000);
    retire(3'd4, rs);
    check("R7 no restart without bypass", int'(rs), 0);
    train(ipA, 1'b1); train(ipA, 1'b1);
    peek(ipA, g);
    check("R4 clear regardless of bypass", int'(g), 0);

    // R8: same-cycle lookup sees the old value
    dispatch(ipB, 3'd5, 16'h0250, 1'b1, g);
    store(16'h0250, 8'b0010_0000);
    @(negedge clk);
    rtValid = 1'b1; rtSlot = 3'd5; lkIp = ipB;
    #1;
    check("R8 lookup sees old value", int'(lkGo), 1);
    check("R7 restart in retire cycle", int'(rtRestart), 1);
    @(posedge clk);
    #1 rtValid = 1'b0;
    check("R8 new value after edge", int'(lkGo), 0);

    // R9/R10: watchdog with limit 1
    doReset(8'd1);
    repeat (3) train(ipB, 1'b1);
    restartSeq(ipA, rs);
    check("R9 first restart", int'(rs), 1);
    for (int k = 0; k < 256; k++) begin
      dispatch(ipAl ^ 32'h0000_1000, 3'd6, 16'h0400, 1'b0, g);
      retire(3'd6, rs);
    end
    restartSeq(ipA, rs);
    check("R9 window cleared, no trip", int'(wdOff), 0);
    restartSeq(ipA, rs);
    check("R9 trip above limit", int'(wdOff), 1);
    rise = cyc;
    peek(ipB, g);
    check("R10 no go while off", int'(g), 0);
    repeat (3) train(ipA, 1'b1);
    peek(ipA, g);
    check("R10 no go for trained entry while off", int'(g), 0);
    while (wdOff) begin
      @(posedge clk);
      #1;
    end
    check("R9 disable length", cyc - rise, HOLD);
    peek(ipA, g);
    check("R10 updates kept while off", int'(g), 1);
    peek(ipB, g);
    check("R10 go restored", int'(g), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule